// File: doc/BRIEF.md
# Serial Link Power State Controller

This block keeps track of the power state of one serial point-to-point link. It has six states. The active state carries traffic. A fast standby state and a deeper low-power state both keep the clock running. A ready state is used as a staging point before main power is removed. There are two power-off states, told apart by whether auxiliary power is still present. Only the active state lets transaction packets and link-layer messages be sent.

Four kinds of input move the link between states:
- autonomous hardware triggers, driven by an internal idle timer and gated by two enable bits;
- a software-controlled device power level;
- wake and handshake indications from either end of the link;
- the main-power and auxiliary-power status.

When power comes back to a link that was switched off, the block returns to the active state and pulses a reinitialization request for one cycle. Electrical signalling and link training are handled elsewhere.

Top module: `link_pwr_ctl`

## Requirements
- R1: After reset, `linkState` is 0 (active), `txAllowed` is 1 and `reinitPulse` is 0. The state codes are: active 0, standby 1, low-power 2, ready 3, aux-sleep 4, off 5.
- R2: `txAllowed` is 1 exactly when `linkState` is 0.
- R3: The idle timer counts cycles in active or standby while `txPending` is 0. It clears in any other cycle. The link goes from active to standby only when `enStandby` is 1 and the count has reached `STANDBY_IDLE`. The transition happens at the edge after the count reaches that value. With `enStandby` at 0 the link stays active however long it is idle.
- R4: In standby, `txPending` at 1 returns the link to active at the next edge. `devPowerLow` has no effect in standby.
- R5: In active, `devPowerLow` at 1 moves the link to low-power at the next edge, whatever the enable bits are.
- R6: With `enLowPower` at 1, the link goes from active or standby to low-power at the edge after the idle count reaches `LOWPWR_IDLE`.
- R7: In low-power, `wakeUp` or `wakeDown` returns the link to active at the next edge.
- R8: `handshakeDone` in active or low-power moves the link to ready at the next edge. It takes priority over every other input.
- R9: In ready, the link stays put while `mainPowerOk` is 1. When `mainPowerOk` is 0, it moves to aux-sleep if `auxPowerOk` is 1, and to off otherwise.
- R10: In aux-sleep or off, `mainPowerOk` at 1 returns the link to active at the next edge. `reinitPulse` is 1 in that one cycle only and is 0 at every other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enStandby | input | 1 | Enables autonomous entry to standby |
| enLowPower | input | 1 | Enables autonomous entry to low-power |
| txPending | input | 1 | A packet or message is waiting to be sent |
| devPowerLow | input | 1 | Software has set the device below full power |
| wakeUp | input | 1 | Wake request from the upstream side |
| wakeDown | input | 1 | Wake request from the downstream side |
| handshakeDone | input | 1 | The power-removal handshake has completed |
| mainPowerOk | input | 1 | Main power is present |
| auxPowerOk | input | 1 | Auxiliary power is present |
| linkState | output | 3 | Current state code (see R1) |
| txAllowed | output | 1 | Packets and link messages may be sent |
| reinitPulse | output | 1 | One-cycle request for full reinitialization |

## Verification
The properties assume that every input is synchronous to `clk` and holds a defined 0 or 1 from time zero. They also assume that main power only drops while the link is in ready, because the block reacts to that status in no other state. The bench drives every input at a known value before reset is released. It changes inputs only just after a rising edge. It clears `mainPowerOk` only while the expected state is ready, aux-sleep or off.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  typedef enum logic [2:0] {
    ST_ACTIVE   = 3'd0,
    ST_STANDBY  = 3'd1,
    ST_LOWPWR   = 3'd2,
    ST_READY    = 3'd3,
    ST_AUXSLEEP = 3'd4,
    ST_OFF      = 3'd5
  } pwrState_t;

  // strobes from control to the idle-timer datapath
  typedef struct packed {
    logic clear;
    logic run;
  } tmrCtl_t;
endpackage

// File: rtl/lpc_idle_timer.sv
module lpc_idle_timer
  import lpc_pkg::*;
#(
  parameter int STANDBY_IDLE = 16,
  parameter int LOWPWR_IDLE  = 256
) (
  input  logic    clk,
  input  logic    rstN,
  input  tmrCtl_t tmrCtl,
  output logic    idleStandby,
  output logic    idleLowPower
);
  localparam int CNT_MAX = (STANDBY_IDLE > LOWPWR_IDLE) ? STANDBY_IDLE : LOWPWR_IDLE;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] idleCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (tmrCtl.clear) begin
      idleCnt <= '0;
    end else if (tmrCtl.run && (idleCnt != CNT_W'(CNT_MAX))) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  assign idleStandby  = (idleCnt >= CNT_W'(STANDBY_IDLE));
  assign idleLowPower = (idleCnt >= CNT_W'(LOWPWR_IDLE));
endmodule

// File: rtl/lpc_state_ctl.sv
module lpc_state_ctl
  import lpc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enStandby,
  input  logic      enLowPower,
  input  logic      txPending,
  input  logic      devPowerLow,
  input  logic      wakeUp,
  input  logic      wakeDown,
  input  logic      handshakeDone,
  input  logic      mainPowerOk,
  input  logic      auxPowerOk,
  input  logic      idleStandby,
  input  logic      idleLowPower,
  output tmrCtl_t   tmrCtl,
  output pwrState_t curState,
  output logic      reinitReq
);
  pwrState_t nextState;
  logic      reinitNext;

  always_comb begin
    nextState  = curState;
    reinitNext = 1'b0;
    unique case (curState)
      ST_ACTIVE: begin
        if (handshakeDone)                    nextState = ST_READY;
        else if (devPowerLow)                 nextState = ST_LOWPWR;
        else if (enLowPower && idleLowPower)  nextState = ST_LOWPWR;
        else if (enStandby && idleStandby)    nextState = ST_STANDBY;
      end
      ST_STANDBY: begin
        if (txPending)                        nextState = ST_ACTIVE;
        else if (enLowPower && idleLowPower)  nextState = ST_LOWPWR;
      end
      ST_LOWPWR: begin
        if (handshakeDone)                    nextState = ST_READY;
        else if (wakeUp || wakeDown)          nextState = ST_ACTIVE;
      end
      ST_READY: begin
        if (!mainPowerOk)
          nextState = auxPowerOk ? ST_AUXSLEEP : ST_OFF;
      end
      ST_AUXSLEEP, ST_OFF: begin
        if (mainPowerOk) begin
          nextState  = ST_ACTIVE;
          reinitNext = 1'b1;
        end
      end
      default: nextState = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState  <= ST_ACTIVE;
      reinitReq <= 1'b0;
    end else begin
      curState  <= nextState;
      reinitReq <= reinitNext;
    end
  end

  always_comb begin
    tmrCtl.run   = ((curState == ST_ACTIVE) || (curState == ST_STANDBY)) && !txPending;
    tmrCtl.clear = !tmrCtl.run;
  end
endmodule

// File: rtl/link_pwr_ctl.sv
module link_pwr_ctl
  import lpc_pkg::*;
#(
  parameter int STANDBY_IDLE = 16,
  parameter int LOWPWR_IDLE  = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enStandby,
  input  logic       enLowPower,
  input  logic       txPending,
  input  logic       devPowerLow,
  input  logic       wakeUp,
  input  logic       wakeDown,
  input  logic       handshakeDone,
  input  logic       mainPowerOk,
  input  logic       auxPowerOk,
  output logic [2:0] linkState,
  output logic       txAllowed,
  output logic       reinitPulse
);
  tmrCtl_t   tmrCtl;
  pwrState_t curState;
  logic      idleStandby;
  logic      idleLowPower;

  lpc_state_ctl ctlInst (
    .clk          (clk),
    .rstN         (rstN),
    .enStandby    (enStandby),
    .enLowPower   (enLowPower),
    .txPending    (txPending),
    .devPowerLow  (devPowerLow),
    .wakeUp       (wakeUp),
    .wakeDown     (wakeDown),
    .handshakeDone(handshakeDone),
    .mainPowerOk  (mainPowerOk),
    .auxPowerOk   (auxPowerOk),
    .idleStandby  (idleStandby),
    .idleLowPower (idleLowPower),
    .tmrCtl       (tmrCtl),
    .curState     (curState),
    .reinitReq    (reinitPulse)
  );

  lpc_idle_timer #(
    .STANDBY_IDLE(STANDBY_IDLE),
    .LOWPWR_IDLE (LOWPWR_IDLE)
  ) tmrInst (
    .clk         (clk),
    .rstN        (rstN),
    .tmrCtl      (tmrCtl),
    .idleStandby (idleStandby),
    .idleLowPower(idleLowPower)
  );

  assign linkState = curState;
  assign txAllowed = (curState == ST_ACTIVE);
endmodule

// File: rtl/link_pwr_ctl_chk.sv
module link_pwr_ctl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       enStandby,
  input logic       txPending,
  input logic       wakeUp,
  input logic       wakeDown,
  input logic       handshakeDone,
  input logic       mainPowerOk,
  input logic       auxPowerOk,
  input logic [2:0] linkState,
  input logic       txAllowed,
  input logic       reinitPulse
);
  // R2
  tx_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    txAllowed |-> (linkState == 3'd0));

  // R2
  tx_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (linkState == 3'd0) |-> txAllowed);

  // R3
  standby_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((linkState == 3'd1) && ($past(linkState) == 3'd0)) |-> $past(enStandby));

  // R4
  standby_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((linkState == 3'd1) && txPending) |=> (linkState == 3'd0));

  // R7
  lowpwr_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((linkState == 3'd2) && (wakeUp || wakeDown) && !handshakeDone) |=> (linkState == 3'd0));

  // R9
  aux_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((linkState == 3'd3) && !mainPowerOk) |=> (linkState == (auxPowerOk ? 3'd4 : 3'd5)));

  // R10
  reinit_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    reinitPulse |-> ((linkState == 3'd0) &&
                     (($past(linkState) == 3'd4) || ($past(linkState) == 3'd5))));

  // R10
  reinit_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    reinitPulse |=> !reinitPulse);
endmodule

bind link_pwr_ctl link_pwr_ctl_chk chkInst (
  .clk          (clk),
  .rstN         (rstN),
  .enStandby    (enStandby),
  .txPending    (txPending),
  .wakeUp       (wakeUp),
  .wakeDown     (wakeDown),
  .handshakeDone(handshakeDone),
  .mainPowerOk  (mainPowerOk),
  .auxPowerOk   (auxPowerOk),
  .linkState    (linkState),
  .txAllowed    (txAllowed),
  .reinitPulse  (reinitPulse)
);

// File: tb/link_pwr_ctl_test.sv
module link_pwr_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int SB_IDLE    = 3;
  localparam int LP_IDLE    = 6;
  localparam int NVEC       = 12;

  // row: {txPending,devPowerLow,wakeUp,wakeDown,handshakeDone,mainPowerOk,auxPowerOk,
  //       enStandby,enLowPower, expState[2:0], expTxAllowed, expReinit}
  localparam logic [13:0] VEC [NVEC] = '{
    {9'b010001100, 3'd2, 1'b0, 1'b0},  // R5 software entry to low-power
    {9'b001001100, 3'd0, 1'b1, 1'b0},  // R7 upstream wake
    {9'b010001100, 3'd2, 1'b0, 1'b0},  // R5
    {9'b000101100, 3'd0, 1'b1, 1'b0},  // R7 downstream wake
    {9'b000011100, 3'd3, 1'b0, 1'b0},  // R8 handshake from active
    {9'b000000100, 3'd4, 1'b0, 1'b0},  // R9 aux present
    {9'b000000100, 3'd4, 1'b0, 1'b0},  // R10 stays without main
    {9'b000001100, 3'd0, 1'b1, 1'b1},  // R10 power back, pulse
    {9'b000001100, 3'd0, 1'b1, 1'b0},  // R10 pulse ends
    {9'b000011100, 3'd3, 1'b0, 1'b0},  // R8
    {9'b000000000, 3'd5, 1'b0, 1'b0},  // R9 no aux
    {9'b000001000, 3'd0, 1'b1, 1'b1}   // R10 from off
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enStandby = 1'b0, enLowPower = 1'b0, txPending = 1'b0, devPowerLow = 1'b0;
  logic wakeUp = 1'b0, wakeDown = 1'b0, handshakeDone = 1'b0;
  logic mainPowerOk = 1'b1, auxPowerOk = 1'b1;
  logic [2:0] linkState;
  logic txAllowed, reinitPulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_pwr_ctl #(.STANDBY_IDLE(SB_IDLE), .LOWPWR_IDLE(LP_IDLE)) uut (
    .clk(clk), .rstN(rstN), .enStandby(enStandby), .enLowPower(enLowPower),
    .txPending(txPending), .devPowerLow(devPowerLow), .wakeUp(wakeUp),
    .wakeDown(wakeDown), .handshakeDone(handshakeDone), .mainPowerOk(mainPowerOk),
    .auxPowerOk(auxPowerOk), .linkState(linkState), .txAllowed(txAllowed),
    .reinitPulse(reinitPulse)
  );

  task automatic check(string req, logic [2:0] st, logic tx, logic ri);
    checks++;
    if (linkState !== st || txAllowed !== tx || reinitPulse !== ri) begin
      fails++;
      $display("FAIL %s: got state=%0d tx=%0b reinit=%0b, expected state=%0d tx=%0b reinit=%0b",
               req, linkState, txAllowed, reinitPulse, st, tx, ri);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic quiet();
    {txPending, devPowerLow, wakeUp, wakeDown, handshakeDone} = '0;
    mainPowerOk = 1'b1;
    auxPowerOk  = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, got hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*2 + 1);
    check("R1", 3'd0, 1'b1, 1'b0);  // R1 during reset
    rstN = 1'b1;
    tick(1);
    check("R1", 3'd0, 1'b1, 1'b0);  // R1 after release

    for (int v = 0; v < NVEC; v++) begin
      {txPending, devPowerLow, wakeUp, wakeDown, handshakeDone,
       mainPowerOk, auxPowerOk, enStandby, enLowPower} = VEC[v][13:5];
      tick(1);
      check($sformatf("R2 vector %0d", v), VEC[v][4:2], VEC[v][1], VEC[v][0]);
    end

    // R3: disabled standby keeps the link active through a long idle stretch
    quiet(); enStandby = 1'b0; enLowPower = 1'b0;
    txPending = 1'b1; tick(1); txPending = 1'b0;
    tick(10);
    check("R3 gate off", 3'd0, 1'b1, 1'b0);

    // R3: standby after STANDBY_IDLE idle cycles, entered at the next edge
    txPending = 1'b1; tick(1); txPending = 1'b0; enStandby = 1'b1;
    tick(SB_IDLE);
    check("R3 before threshold", 3'd0, 1'b1, 1'b0);
    tick(1);
    check("R3 entry", 3'd1, 1'b0, 1'b0);
    devPowerLow = 1'b1;
    tick(5);
    check("R4 devPowerLow ignored in standby", 3'd1, 1'b0, 1'b0);
    devPowerLow = 1'b0;
    txPending = 1'b1; tick(1);
    check("R4 exit", 3'd0, 1'b1, 1'b0);

    // R6: autonomous low-power through standby
    txPending = 1'b0; enLowPower = 1'b1;
    tick(SB_IDLE + 1);
    check("R6 via standby", 3'd1, 1'b0, 1'b0);
    tick(LP_IDLE - SB_IDLE - 1);
    check("R6 before threshold", 3'd1, 1'b0, 1'b0);
    tick(1);
    check("R6 entry", 3'd2, 1'b0, 1'b0);
    enStandby = 1'b0; enLowPower = 1'b0;
    wakeUp = 1'b1; tick(1); wakeUp = 1'b0;
    check("R7 wake", 3'd0, 1'b1, 1'b0);

    // R8: handshake beats wake in low-power
    devPowerLow = 1'b1; tick(1); devPowerLow = 1'b0;
    check("R5 entry", 3'd2, 1'b0, 1'b0);
    handshakeDone = 1'b1; wakeUp = 1'b1; wakeDown = 1'b1; tick(1);
    quiet();
    check("R8 priority", 3'd3, 1'b0, 1'b0);
    tick(3);
    check("R9 holds with main", 3'd3, 1'b0, 1'b0);

    // R1: reset from a non-active state
    rstN = 1'b0; #2;
    check("R1 async reset", 3'd0, 1'b1, 1'b0);
    tick(1); rstN = 1'b1; tick(1);
    check("R1 after second reset", 3'd0, 1'b1, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule